// File: doc/BRIEF.md
# Console Memory Address Decoder with Cycle Stretching

This block sits between a 16-bit-capable CPU core and the rest of a console's memory system. It looks at the 24-bit address the core puts out, the two qualifiers that say whether the address is an opcode/operand fetch or a data access, and the read/write direction. From these it builds the active-low read and write strobes for the two external buses and the chip selects for the work RAM and the cartridge. It also picks how many master clocks the current CPU cycle takes.

The speed comes from a fixed bank/offset map with three lengths: fast, slow and extra-slow. The cartridge ROM in the upper half of the address space can be switched between fast and slow by a single enable bit. A cycle in which neither qualifier is set is an internal operation. Such a cycle always runs at the fast length and drives no strobe, whatever address is on the bus.

A master-clock counter stretches each CPU cycle to the chosen length. All decoded outputs are sampled on the edge that starts a CPU cycle and held until the next one. A one-clock done strobe marks the last master clock of each cycle, and the core uses it to advance.

Top module: `mclk_bus_decoder`

## Requirements
- R1: An access is valid when either qualifier (`vda_i` or `vpa_i`) is 1. An access is a read when it is valid and `rwb_i`=1, and a write when it is valid and `rwb_i`=0. For a valid access on the A bus, `cpurd_n_o` is 0 on a read and `cpuwr_n_o` is 0 on a write. The A bus covers every address that is neither B bus nor internal register.
- R2: In banks 00–3F and 80–BF, offsets 2100–21FF are the B bus. A valid read there drives `pard_n_o`=0 and a valid write drives `pawr_n_o`=0. Neither A-bus strobe is asserted there.
- R3: In banks 00–3F and 80–BF, offsets 4000–43FF are internal registers. None of the four bus strobes is asserted there.
- R4: `wram_n_o` is 0 for banks 7E–7F, and for offsets 0000–1FFF in banks 00–3F and 80–BF. It is 1 for all other addresses. This chip select is decoded from the address alone.
- R5: `cart_n_o` is 0 for offsets 8000–FFFF in any bank, and for banks 40–7F and C0–FF except 7E–7F. It is 1 for all other addresses. This chip select is decoded from the address alone.
- R6: When `vda_i`=`vpa_i`=0 (an internal operation), the four bus strobes stay at 1 and the cycle lasts FAST_CLKS (6) master clocks.
- R7: A valid cycle in banks 00–3F or 80–BF lasts a set number of master clocks, depending on the offset:
  - 6 (fast) for offsets 2000–3FFF and 4200–5FFF;
  - 8 (slow) for offsets 0000–1FFF and 6000–7FFF;
  - 12 (extra-slow) for offsets 4000–41FF.
  
  A valid cycle in banks 40–7F lasts 8 clocks. So does a valid cycle at offsets 8000–FFFF in banks 00–3F.
- R8: A valid cycle in banks C0–FF, or at offsets 8000–FFFF in banks 80–BF, lasts 6 clocks when `fast_rom_i`=1 and 8 clocks when it is 0.
- R9: The inputs are sampled on the rising edge that starts a CPU cycle. This is the first edge after reset is released, and then every edge on which `cycle_done_o` is 1. The strobes, the selects and `cycle_clks_o` (the length as a binary count) are held for the whole cycle, even if the inputs change during it. `cycle_done_o` is 1 for exactly the last of the `cycle_clks_o` master clocks.
- R10: While `rst_i`=1, all six active-low outputs are 1, `cycle_clks_o` is 0 and `cycle_done_o` is 0. Reset in the middle of a cycle discards the partial count, and the first cycle after reset runs its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 24 | CPU address: bank in [23:16], offset in [15:0] |
| vda_i | input | 1 | Valid data address qualifier |
| vpa_i | input | 1 | Valid program address qualifier |
| rwb_i | input | 1 | 1 = read, 0 = write |
| fast_rom_i | input | 1 | Fast-ROM enable for the upper ROM regions |
| cpurd_n_o | output | 1 | A-bus read strobe, active low |
| cpuwr_n_o | output | 1 | A-bus write strobe, active low |
| pard_n_o | output | 1 | B-bus read strobe, active low |
| pawr_n_o | output | 1 | B-bus write strobe, active low |
| cart_n_o | output | 1 | Cartridge select, active low |
| wram_n_o | output | 1 | Work-RAM select, active low |
| cycle_clks_o | output | CNT_W (4) | Master clocks in the current CPU cycle |
| cycle_done_o | output | 1 | High on the last master clock of the cycle |

## Verification
The bench walks the edges of the speed map: the boundary between the extra-slow 41FF and the fast 4200, the fast 5FFF against the slow 6000, and the B-bus window against its A-bus neighbours. A decoder with an off-by-one mask would give the wrong length or assert the wrong strobe at these addresses. It also checks the upper ROM with both settings of the fast-ROM bit, and the work-RAM banks at offsets 8000–FFFF, where both chip selects must be active together. A design that let the work-RAM bank override the cartridge select would miss that case. An internal operation aimed at an extra-slow register and at the RAM mirror checks that the fast length wins and that the strobes stay high while the address-only selects still follow the address. A last set of directed tests changes the inputs in the middle of a cycle and resets in the middle of a long cycle. These catch a timer that re-samples its inputs or keeps a stale count.

// File: rtl/mclk_bus_pkg.sv
package mclk_bus_pkg;

  typedef enum logic [1:0] {
    SPD_FAST  = 2'd0,
    SPD_SLOW  = 2'd1,
    SPD_XSLOW = 2'd2
  } speed_e;

  // Active-low strobes and selects, in output order
  typedef struct packed {
    logic cpurd_n;
    logic cpuwr_n;
    logic pard_n;
    logic pawr_n;
    logic cart_n;
    logic wram_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{default: 1'b1};

endpackage

// File: rtl/mclk_bus_region.sv
module mclk_bus_region
  import mclk_bus_pkg::*;
(
  input  logic [7:0] bank_i,
  input  logic [7:0] hbyte_i,
  input  logic       vda_i,
  input  logic       vpa_i,
  input  logic       rwb_i,
  output strobe_t    strobe_o
);

  logic valid, rd, wr;
  logic low_bank, wram_bank, cart_bank;
  logic wram_mirror, b_bus, int_reg, hi_half, a_bus;

  always_comb begin
    valid = vda_i | vpa_i;
    rd    = valid & rwb_i;
    wr    = valid & ~rwb_i;

    low_bank  = (bank_i[6] == 1'b0);
    wram_bank = (bank_i[7:1] == 7'b0111111);
    cart_bank = ~wram_bank & bank_i[6];

    wram_mirror = low_bank & (hbyte_i[7:5] == 3'b000);
    b_bus       = low_bank & (hbyte_i == 8'h21);
    int_reg     = low_bank & (hbyte_i[7:2] == 6'b010000);
    hi_half     = hbyte_i[7];
    a_bus       = ~(int_reg | b_bus);

    strobe_o.cpurd_n = ~(a_bus & rd);
    strobe_o.cpuwr_n = ~(a_bus & wr);
    strobe_o.pard_n  = ~(b_bus & rd);
    strobe_o.pawr_n  = ~(b_bus & wr);
    strobe_o.cart_n  = ~(hi_half | cart_bank);
    strobe_o.wram_n  = ~(wram_mirror | wram_bank);
  end

endmodule

// File: rtl/mclk_bus_speed.sv
module mclk_bus_speed
  import mclk_bus_pkg::*;
#(
  parameter int FAST_CLKS  = 6,
  parameter int SLOW_CLKS  = 8,
  parameter int XSLOW_CLKS = 12,
  parameter int CNT_W      = $clog2(XSLOW_CLKS + 1)
) (
  input  logic [7:0]       bank_i,
  input  logic [7:0]       hbyte_i,
  input  logic             vda_i,
  input  logic             vpa_i,
  input  logic             fast_rom_i,
  output logic [CNT_W-1:0] len_o
);

  localparam logic [CNT_W-1:0] LEN_FAST  = CNT_W'(FAST_CLKS);
  localparam logic [CNT_W-1:0] LEN_SLOW  = CNT_W'(SLOW_CLKS);
  localparam logic [CNT_W-1:0] LEN_XSLOW = CNT_W'(XSLOW_CLKS);

  speed_e spd;
  speed_e rom_spd;

  always_comb begin
    rom_spd = fast_rom_i ? SPD_FAST : SPD_SLOW;
    spd     = SPD_SLOW;
    if (!(vda_i | vpa_i)) begin
      spd = SPD_FAST;                       // internal operation
    end else if (bank_i[6]) begin
      spd = bank_i[7] ? rom_spd : SPD_SLOW;  // C0-FF vs 40-7F
    end else if (hbyte_i[7]) begin
      spd = bank_i[7] ? rom_spd : SPD_SLOW;  // ROM half of lower banks
    end else begin
      unique case (hbyte_i[6:5])
        2'b00: spd = SPD_SLOW;               // 0000-1FFF
        2'b01: spd = SPD_FAST;               // 2000-3FFF
        2'b10: spd = (hbyte_i[4:1] == 4'b0000) ? SPD_XSLOW : SPD_FAST;
        default: spd = SPD_SLOW;             // 6000-7FFF
      endcase
    end
  end

  always_comb begin
    unique case (spd)
      SPD_FAST:  len_o = LEN_FAST;
      SPD_XSLOW: len_o = LEN_XSLOW;
      default:   len_o = LEN_SLOW;
    endcase
  end

endmodule

// File: rtl/mclk_bus_timer.sv
module mclk_bus_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [CNT_W-1:0] len_next_i,
  output logic             start_o,
  output logic [CNT_W-1:0] len_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic             last;

  assign last    = active_q && (cnt_q == (len_q - ONE));
  assign start_o = !active_q || last;
  assign done_o  = last;
  assign len_o   = len_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
    end else if (start_o) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      len_q    <= len_next_i;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

endmodule

// File: rtl/mclk_bus_decoder.sv
module mclk_bus_decoder
  import mclk_bus_pkg::*;
#(
  parameter int FAST_CLKS  = 6,
  parameter int SLOW_CLKS  = 8,
  parameter int XSLOW_CLKS = 12,
  parameter int CNT_W      = $clog2(XSLOW_CLKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [23:0]      addr_i,
  input  logic             vda_i,
  input  logic             vpa_i,
  input  logic             rwb_i,
  input  logic             fast_rom_i,
  output logic             cpurd_n_o,
  output logic             cpuwr_n_o,
  output logic             pard_n_o,
  output logic             pawr_n_o,
  output logic             cart_n_o,
  output logic             wram_n_o,
  output logic [CNT_W-1:0] cycle_clks_o,
  output logic             cycle_done_o
);

  logic [7:0] bank, hbyte;
  logic       unused_low_byte;

  assign bank            = addr_i[23:16];
  assign hbyte           = addr_i[15:8];
  assign unused_low_byte = ^addr_i[7:0];

  strobe_t          dec_strobe;
  strobe_t          strobe_q;
  logic [CNT_W-1:0] len_next;
  logic             start;

  mclk_bus_region u_region (
    .bank_i   (bank),
    .hbyte_i  (hbyte),
    .vda_i    (vda_i),
    .vpa_i    (vpa_i),
    .rwb_i    (rwb_i),
    .strobe_o (dec_strobe)
  );

  mclk_bus_speed #(
    .FAST_CLKS  (FAST_CLKS),
    .SLOW_CLKS  (SLOW_CLKS),
    .XSLOW_CLKS (XSLOW_CLKS),
    .CNT_W      (CNT_W)
  ) u_speed (
    .bank_i     (bank),
    .hbyte_i    (hbyte),
    .vda_i      (vda_i),
    .vpa_i      (vpa_i),
    .fast_rom_i (fast_rom_i),
    .len_o      (len_next)
  );

  mclk_bus_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .len_next_i (len_next),
    .start_o    (start),
    .len_o      (cycle_clks_o),
    .done_o     (cycle_done_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      strobe_q <= STROBE_IDLE;
    end else if (start) begin
      strobe_q <= dec_strobe;
    end
  end

  assign cpurd_n_o = strobe_q.cpurd_n;
  assign cpuwr_n_o = strobe_q.cpuwr_n;
  assign pard_n_o  = strobe_q.pard_n;
  assign pawr_n_o  = strobe_q.pawr_n;
  assign cart_n_o  = strobe_q.cart_n;
  assign wram_n_o  = strobe_q.wram_n;

endmodule

// File: rtl/mclk_bus_decoder_chk.sv
module mclk_bus_decoder_chk #(
  parameter int FAST_CLKS  = 6,
  parameter int SLOW_CLKS  = 8,
  parameter int XSLOW_CLKS = 12,
  parameter int CNT_W      = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             vda_i,
  input logic             vpa_i,
  input logic             cpurd_n_o,
  input logic             cpuwr_n_o,
  input logic             pard_n_o,
  input logic             pawr_n_o,
  input logic             cart_n_o,
  input logic             wram_n_o,
  input logic [CNT_W-1:0] cycle_clks_o,
  input logic             cycle_done_o
);

  logic             seen_q;
  logic [CNT_W-1:0] ck_cnt;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      seen_q <= 1'b0;
      ck_cnt <= '0;
    end else begin
      seen_q <= 1'b1;
      if (seen_q) ck_cnt <= cycle_done_o ? '0 : ck_cnt + 1'b1;
    end
  end

  // R1 R2: at most one bus strobe low at a time
  a_r1_one_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(~{cpurd_n_o, cpuwr_n_o, pard_n_o, pawr_n_o}) <= 1);

  // R6: a cycle started on an internal operation drives no strobe, fast length
  a_r6_internal_op: assert property (@(posedge clk_i) disable iff (rst_i)
    (cycle_done_o && !vda_i && !vpa_i) |=>
      ({cpurd_n_o, cpuwr_n_o, pard_n_o, pawr_n_o} == 4'hF) &&
      (cycle_clks_o == CNT_W'(FAST_CLKS)));

  // R7: length is always one of the three map values once running
  a_r7_legal_len: assert property (@(posedge clk_i) disable iff (rst_i)
    seen_q |-> (cycle_clks_o == CNT_W'(FAST_CLKS) ||
                cycle_clks_o == CNT_W'(SLOW_CLKS) ||
                cycle_clks_o == CNT_W'(XSLOW_CLKS)));

  // R9: outputs hold until a cycle ends
  a_r9_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (seen_q && !cycle_done_o) |=>
      $stable({cpurd_n_o, cpuwr_n_o, pard_n_o, pawr_n_o, cart_n_o, wram_n_o, cycle_clks_o}));

  // R9: done is a single-clock pulse
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    cycle_done_o |=> !cycle_done_o);

  // R9: done lands on the last clock of the selected length
  a_r9_done_width: assert property (@(posedge clk_i) disable iff (rst_i)
    (seen_q && cycle_done_o) |-> (ck_cnt == cycle_clks_o - 1'b1));

endmodule

bind mclk_bus_decoder mclk_bus_decoder_chk #(
  .FAST_CLKS  (FAST_CLKS),
  .SLOW_CLKS  (SLOW_CLKS),
  .XSLOW_CLKS (XSLOW_CLKS),
  .CNT_W      (CNT_W)
) u_chk (.*);

// File: tb/mclk_bus_decoder_tb.sv
module mclk_bus_decoder_tb;

  localparam int NV = 24;

  // {bank, offset, vda, vpa, rwb, fast_rom, cpurd,cpuwr,pard,pawr,cart,wram, len}
  localparam logic [37:0] VEC [NV] = '{
    {8'h7E, 16'h1234, 4'b1010, 6'b011110, 4'd8},
    {8'h00, 16'h0100, 4'b1000, 6'b101110, 4'd8},
    {8'h00, 16'h2118, 4'b1000, 6'b111011, 4'd6},
    {8'h80, 16'h2140, 4'b1010, 6'b110111, 4'd6},
    {8'h00, 16'h4016, 4'b1010, 6'b111111, 4'd12},
    {8'h00, 16'h4200, 4'b1000, 6'b111111, 4'd6},
    {8'h00, 16'h8000, 4'b0111, 6'b011101, 4'd8},
    {8'h80, 16'h8000, 4'b0111, 6'b011101, 4'd6},
    {8'h80, 16'h8000, 4'b0110, 6'b011101, 4'd8},
    {8'hC0, 16'h0000, 4'b1011, 6'b011101, 4'd6},
    {8'hFF, 16'hFFFF, 4'b0110, 6'b011101, 4'd8},
    {8'h40, 16'h0000, 4'b1011, 6'b011101, 4'd8},
    {8'h7F, 16'hFFFF, 4'b1001, 6'b101100, 4'd8},
    {8'h00, 16'h4016, 4'b0010, 6'b111111, 4'd6},
    {8'h00, 16'h1000, 4'b0000, 6'b111110, 4'd6},
    {8'h00, 16'h6000, 4'b1010, 6'b011111, 4'd8},
    {8'h00, 16'h2000, 4'b1010, 6'b011111, 4'd6},
    {8'h00, 16'h5FFF, 4'b1010, 6'b011111, 4'd6},
    {8'h00, 16'h4400, 4'b1010, 6'b011111, 4'd6},
    {8'h00, 16'h41FF, 4'b1010, 6'b111111, 4'd12},
    {8'h00, 16'h21FF, 4'b0110, 6'b110111, 4'd6},
    {8'h40, 16'h2100, 4'b1010, 6'b011101, 4'd8},
    {8'hBF, 16'h1FFF, 4'b1000, 6'b101110, 4'd8},
    {8'hC0, 16'h4016, 4'b1011, 6'b011101, 4'd6}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] addr = '0;
  logic        vda = 1'b0, vpa = 1'b0, rwb = 1'b1, fast_rom = 1'b0;
  logic        cpurd_n, cpuwr_n, pard_n, pawr_n, cart_n, wram_n;
  logic [3:0]  clks;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mclk_bus_decoder u_dut (
    .clk_i(clk), .rst_i(rst), .addr_i(addr), .vda_i(vda), .vpa_i(vpa),
    .rwb_i(rwb), .fast_rom_i(fast_rom),
    .cpurd_n_o(cpurd_n), .cpuwr_n_o(cpuwr_n), .pard_n_o(pard_n),
    .pawr_n_o(pawr_n), .cart_n_o(cart_n), .wram_n_o(wram_n),
    .cycle_clks_o(clks), .cycle_done_o(done)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [37:0] v);
    addr     = v[37:14];
    {vda, vpa, rwb, fast_rom} = v[13:10];
  endtask

  // Inputs already applied; the next rising edge starts a cycle.
  task automatic run_cycle(input logic [5:0] exp_s, input int exp_len, input int idx);
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        check($sformatf("R1 R2 R3 R6 strobes vec%0d", idx),
              {cpurd_n, cpuwr_n, pard_n, pawr_n}, exp_s[5:2]);
        check($sformatf("R4 R5 selects vec%0d", idx), {cart_n, wram_n}, exp_s[1:0]);
        check($sformatf("R7 R8 R6 length vec%0d", idx), clks, exp_len);
      end
      if (done || k > 40) break;
    end
    check($sformatf("R9 done position vec%0d", idx), k, exp_len);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10: reset values
    check("R10 reset strobes", {cpurd_n, cpuwr_n, pard_n, pawr_n, cart_n, wram_n}, 6'h3F);
    check("R10 reset clks", clks, 0);
    check("R10 reset done", done, 0);

    apply(VEC[0]);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      run_cycle(VEC[i][9:4], int'(VEC[i][3:0]), i);
    end

    // R9: inputs changing mid-cycle have no effect on the running cycle
    apply(VEC[4]);
    begin
      int k = 0;
      forever begin
        @(negedge clk);
        k++;
        if (k == 2) apply(VEC[2]);
        if (k == 6) begin
          check("R9 hold strobes", {cpurd_n, cpuwr_n, pard_n, pawr_n, cart_n, wram_n}, 6'h3F);
          check("R9 hold clks", clks, 12);
        end
        if (done || k > 40) break;
      end
      check("R9 hold length", k, 12);
    end
    run_cycle(VEC[2][9:4], 6, 102);

    // R10: reset in the middle of a long cycle
    apply(VEC[19]);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid reset strobes", {cpurd_n, cpuwr_n, pard_n, pawr_n, cart_n, wram_n}, 6'h3F);
    check("R10 mid reset clks", clks, 0);
    check("R10 mid reset done", done, 0);
    apply(VEC[16]);
    rst = 1'b0;
    run_cycle(VEC[16][9:4], 6, 116);
    apply(VEC[19]);
    run_cycle(VEC[19][9:4], 12, 119);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule